// File: doc/BRIEF.md
# CPU Bus Address Decoder

This block sits between a 16-bit-data, 24-bit-address CPU bus and the targets of a home-computer memory map. For every bus access it chooses one target: ordinary memory named by a per-region table, a pair of 8-bit peripheral chips that share one address window on opposite data byte lanes, a custom-chip register port, an expansion-configuration port, or open bus. It drives the chip selects and the peripheral register index. It merges the peripheral byte lanes and the other targets' data onto one read bus. It raises the valid-peripheral-address signal, and it holds off chip-RAM accesses until a shared-bus arbiter grants a CPU slot.

The region table has one entry per 256 KB region. Each entry carries a two-bit access mask and a six-bit bank number that is passed to the memory arrays. The table is loaded through a configuration write port. On reset it returns to a boot map in which ROM also shows at address 0. The decode is combinational from the bus inputs. The only state is the region table and the pending-wait flag.

Top module: `cpu_addr_decode`

## Requirements
- R1: `vpa` is high when `busSelect` is high and address bits 23:21 are 3'b101, and during any interrupt-acknowledge cycle. It is low for every other access.
- R2: In the peripheral window, `periphASel` is high when address bit 12 is 0 and `periphBSel` is high when address bit 13 is 0. Both may be high together, and `periphReg` carries address bits 11:8.
- R3: On a peripheral write, `periphWrEn` is high, chip A receives `busWrData[7:0]` and chip B receives `busWrData[15:8]`.
- R4: A peripheral read returns chip B's byte on bits 15:8 and chip A's byte on bits 7:0. A lane whose chip is not selected reads 8'hFF.
- R5: Addresses 0xDFF000 through 0xDFF1BE inclusive assert `customSel` and read `customRdData`. Address 0xDFF1C0 does not.
- R6: Addresses 0xE80000 through 0xE8FFFF assert `expSel` and read `expRdData`. Address 0xE90000 does not.
- R7: Any other access with a zero-mask region reads 16'hFFFF and asserts no select, so a write there has no effect.
- R8: A region whose mask is non-zero is memory and overrides the chip decode. Mask bit 0 permits reads and mask bit 1 permits writes. `memSel` is high only for a permitted access, `memBank` gives the entry's bank, and a read that is not permitted returns 16'hFFFF.
- R9: After reset the table holds these entries:
  - region 0: mask 2'b01, bank 63 (ROM overlay);
  - regions 1 to 7: mask 2'b11, bank equal to the region number;
  - regions 62 and 63: mask 2'b01, bank equal to the region number;
  - all other regions: mask 0.
- R10: A clock edge with `cfgWe` high writes `{cfgMask, cfgBank}` into entry `cfgIdx`. The new entry takes effect from the next cycle.
- R11: When `busNewAddr` is high for an address below 0x200000 and `slotGrant` is low, `waitReq` rises in the same cycle. It stays high until a cycle in which `slotGrant` is high, and `waitReq` is low in that cycle.
- R12: During an interrupt-acknowledge cycle no select is asserted, `waitReq` stays low and the read data is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 24 | CPU byte address |
| busSelect | input | 1 | A byte or word transfer is in progress |
| busNewAddr | input | 1 | First cycle of a new address |
| busRead | input | 1 | 1 = read, 0 = write |
| busIack | input | 1 | Interrupt-acknowledge cycle |
| busWrData | input | 16 | CPU write data |
| busRdData | output | 16 | Merged read data to the CPU |
| vpa | output | 1 | Valid peripheral address |
| waitReq | output | 1 | Insert wait states |
| slotGrant | input | 1 | Arbiter grants the CPU a bus slot |
| periphASel | output | 1 | Chip select, peripheral A (low lane) |
| periphBSel | output | 1 | Chip select, peripheral B (high lane) |
| periphWrEn | output | 1 | Peripheral write strobe |
| periphReg | output | 4 | Peripheral register index |
| periphAWrData | output | 8 | Write byte to peripheral A |
| periphBWrData | output | 8 | Write byte to peripheral B |
| periphARdData | input | 8 | Read byte from peripheral A |
| periphBRdData | input | 8 | Read byte from peripheral B |
| customSel | output | 1 | Custom-chip register port select |
| customRdData | input | 16 | Custom-chip read data |
| expSel | output | 1 | Expansion-configuration port select |
| expRdData | input | 16 | Expansion-configuration read data |
| memSel | output | 1 | Permitted ordinary memory access |
| memWrEn | output | 1 | Memory write strobe |
| memBank | output | 6 | Bank number from the region entry |
| memRdData | input | 16 | Memory read data |
| cfgWe | input | 1 | Region table write enable |
| cfgIdx | input | 6 | Region table entry to write |
| cfgMask | input | 2 | Access mask to write (bit0 read, bit1 write) |
| cfgBank | input | 6 | Bank number to write |

## Verification
The hardest situation to bring about is a table entry that shadows the peripheral window. The default map never covers that window. The bench therefore writes a read/write entry into region 47, the region that holds 0xBFE001. It then checks that memory wins while `vpa` stays high, and that a second reset restores the chip decode. Held waits are also covered. The bench keeps `slotGrant` low across a clock edge after the new-address cycle, with `busNewAddr` already dropped, and only then grants the slot.

// File: rtl/cpu_addr_decode_pkg.sv
package cpu_addr_decode_pkg;
  localparam int ADDR_W   = 24;
  localparam int REGION_W = 6;
  localparam int BANK_W   = 6;
  localparam int REGIONS  = 1 << REGION_W;

  typedef struct packed {
    logic [1:0]        mask;   // bit0 read permitted, bit1 write permitted
    logic [BANK_W-1:0] bank;
  } regionEntry_t;

  typedef struct packed {
    logic iack;
    logic memHit;
    logic memRd;
    logic memWr;
    logic periph;
    logic selA;
    logic selB;
    logic custom;
    logic expCfg;
  } strobe_t;
endpackage

// File: rtl/cpu_addr_decode_ctrl.sv
module cpu_addr_decode_ctrl
  import cpu_addr_decode_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHIP_RAM_END = 24'h200000,
  parameter logic [ADDR_W-1:0] CUSTOM_LO    = 24'hDFF000,
  parameter logic [ADDR_W-1:0] CUSTOM_HI    = 24'hDFF1BE,
  parameter logic [ADDR_W-1:0] EXP_LO       = 24'hE80000,
  parameter logic [ADDR_W-1:0] EXP_END      = 24'hE90000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busSelect,
  input  logic              busNewAddr,
  input  logic              busRead,
  input  logic              busIack,
  input  logic              slotGrant,
  input  regionEntry_t      entry,
  output strobe_t           strb,
  output logic              vpa,
  output logic              waitReq
);
  logic valid, inWin, memHit, notMem, chipStart, pendingQ;

  always_comb begin
    valid  = busSelect && !busIack;
    inWin  = (busAddr[23:21] == 3'b101);
    memHit = valid && (entry.mask != 2'b00);
    notMem = valid && !memHit;

    strb        = '0;
    strb.iack   = busIack;
    strb.memHit = memHit;
    strb.memRd  = memHit && busRead && entry.mask[0];
    strb.memWr  = memHit && !busRead && entry.mask[1];
    strb.periph = notMem && inWin;
    strb.selA   = notMem && inWin && !busAddr[12];
    strb.selB   = notMem && inWin && !busAddr[13];
    strb.custom = notMem && !inWin && (busAddr >= CUSTOM_LO) && (busAddr <= CUSTOM_HI);
    strb.expCfg = notMem && (busAddr >= EXP_LO) && (busAddr < EXP_END);

    vpa       = busIack || (busSelect && inWin);
    chipStart = busNewAddr && !busIack && (busAddr < CHIP_RAM_END);
    waitReq   = (chipStart || pendingQ) && !slotGrant;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= 1'b0;
    else       pendingQ <= waitReq;
  end

  assert_wait_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (waitReq && !slotGrant) |=> (waitReq || slotGrant));
  assert_wait_grant_R11: assert property (@(posedge clk) disable iff (!rstN)
    slotGrant |-> !waitReq);
  assert_periph_vpa_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selA || strb.selB) |-> vpa);
  assert_iack_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    busIack |-> (!strb.memHit && !strb.periph && !strb.custom && !strb.expCfg && vpa));
endmodule

// File: rtl/cpu_addr_decode_dp.sv
module cpu_addr_decode_dp
  import cpu_addr_decode_pkg::*;
#(
  parameter int RAM_LAST_REGION  = 7,
  parameter int ROM_FIRST_REGION = 62,
  parameter logic [BANK_W-1:0] OVERLAY_BANK = 6'd63
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [15:0]         busWrData,
  input  strobe_t             strb,
  input  logic                cfgWe,
  input  logic [REGION_W-1:0] cfgIdx,
  input  logic [1:0]          cfgMask,
  input  logic [BANK_W-1:0]   cfgBank,
  input  logic [7:0]          periphARdData,
  input  logic [7:0]          periphBRdData,
  input  logic [15:0]         customRdData,
  input  logic [15:0]         expRdData,
  input  logic [15:0]         memRdData,
  output regionEntry_t        entry,
  output logic [15:0]         busRdData,
  output logic [3:0]          periphReg,
  output logic [7:0]          periphAWrData,
  output logic [7:0]          periphBWrData
);
  localparam int REGION_LSB = ADDR_W - REGION_W;

  regionEntry_t tableQ [REGIONS];

  function automatic regionEntry_t bootEntry(int idx);
    regionEntry_t e;
    e.bank = BANK_W'(idx);
    if (idx == 0) begin
      e.mask = 2'b01;
      e.bank = OVERLAY_BANK;
    end else if (idx <= RAM_LAST_REGION) e.mask = 2'b11;
    else if (idx >= ROM_FIRST_REGION)   e.mask = 2'b01;
    else                                e.mask = 2'b00;
    return e;
  endfunction

  for (genvar g = 0; g < REGIONS; g++) begin : g_region
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 tableQ[g] <= bootEntry(g);
      else if (cfgWe && cfgIdx == REGION_W'(g)) tableQ[g] <= '{mask: cfgMask, bank: cfgBank};
    end
  end

  assign entry         = tableQ[busAddr[ADDR_W-1:REGION_LSB]];
  assign periphReg     = busAddr[11:8];
  assign periphAWrData = busWrData[7:0];
  assign periphBWrData = busWrData[15:8];

  always_comb begin
    busRdData = 16'hFFFF;
    if (strb.iack)        busRdData = 16'hFFFF;
    else if (strb.memHit) busRdData = strb.memRd ? memRdData : 16'hFFFF;
    else if (strb.periph) busRdData = {strb.selB ? periphBRdData : 8'hFF,
                                       strb.selA ? periphARdData : 8'hFF};
    else if (strb.custom) busRdData = customRdData;
    else if (strb.expCfg) busRdData = expRdData;
  end

  assert_lane_a_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.periph && !strb.selA) |-> (busRdData[7:0] == 8'hFF));
  assert_lane_b_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.periph && !strb.selB) |-> (busRdData[15:8] == 8'hFF));
  assert_cfg_lands_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (tableQ[$past(cfgIdx)].mask == $past(cfgMask)));
endmodule

// File: rtl/cpu_addr_decode.sv
module cpu_addr_decode
  import cpu_addr_decode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [23:0] busAddr,
  input  logic        busSelect,
  input  logic        busNewAddr,
  input  logic        busRead,
  input  logic        busIack,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        vpa,
  output logic        waitReq,
  input  logic        slotGrant,
  output logic        periphASel,
  output logic        periphBSel,
  output logic        periphWrEn,
  output logic [3:0]  periphReg,
  output logic [7:0]  periphAWrData,
  output logic [7:0]  periphBWrData,
  input  logic [7:0]  periphARdData,
  input  logic [7:0]  periphBRdData,
  output logic        customSel,
  input  logic [15:0] customRdData,
  output logic        expSel,
  input  logic [15:0] expRdData,
  output logic        memSel,
  output logic        memWrEn,
  output logic [5:0]  memBank,
  input  logic [15:0] memRdData,
  input  logic        cfgWe,
  input  logic [5:0]  cfgIdx,
  input  logic [1:0]  cfgMask,
  input  logic [5:0]  cfgBank
);
  strobe_t      strb;
  regionEntry_t entry;

  cpu_addr_decode_ctrl ctrl_i (
    .clk, .rstN, .busAddr, .busSelect, .busNewAddr, .busRead, .busIack,
    .slotGrant, .entry, .strb, .vpa, .waitReq
  );

  cpu_addr_decode_dp dp_i (
    .clk, .rstN, .busAddr, .busWrData, .strb, .cfgWe, .cfgIdx, .cfgMask, .cfgBank,
    .periphARdData, .periphBRdData, .customRdData, .expRdData, .memRdData,
    .entry, .busRdData, .periphReg, .periphAWrData, .periphBWrData
  );

  assign periphASel = strb.selA;
  assign periphBSel = strb.selB;
  assign periphWrEn = (strb.selA || strb.selB) && !busRead;
  assign customSel  = strb.custom;
  assign expSel     = strb.expCfg;
  assign memSel     = strb.memRd || strb.memWr;
  assign memWrEn    = strb.memWr;
  assign memBank    = entry.bank;

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memSel, periphASel || periphBSel, customSel, expSel}));
endmodule

// File: tb/cpu_addr_decode_tb_top.sv
module cpu_addr_decode_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic busSelect = 0, busNewAddr = 0, busRead = 1, busIack = 0, slotGrant = 0;
  logic [15:0] busWrData = '0, busRdData;
  logic vpa, waitReq, periphASel, periphBSel, periphWrEn, customSel, expSel, memSel, memWrEn;
  logic [3:0] periphReg;
  logic [7:0] periphAWrData, periphBWrData;
  logic [5:0] memBank;
  logic cfgWe = 0;
  logic [5:0] cfgIdx = '0, cfgBank = '0;
  logic [1:0] cfgMask = '0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cpu_addr_decode dut_i (
    .clk, .rstN, .busAddr, .busSelect, .busNewAddr, .busRead, .busIack, .busWrData,
    .busRdData, .vpa, .waitReq, .slotGrant, .periphASel, .periphBSel, .periphWrEn,
    .periphReg, .periphAWrData, .periphBWrData,
    .periphARdData(8'h5A), .periphBRdData(8'hC3),
    .customSel, .customRdData(16'h1234), .expSel, .expRdData(16'hBEEF),
    .memSel, .memWrEn, .memBank, .memRdData(16'h7777),
    .cfgWe, .cfgIdx, .cfgMask, .cfgBank
  );

  typedef struct packed {
    logic [23:0] addr;
    logic vpa, a, b, cus, ex, mem;
    logic [15:0] rd;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{24'hBFE001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFF5A},
    '{24'hBFD000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC3FF},
    '{24'hBFC000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC35A},
    '{24'hBFF000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    '{24'hA00000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hC35A},
    '{24'hDFF000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1234},
    '{24'hDFF1BE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1234},
    '{24'hDFF1C0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    '{24'hE80000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hBEEF},
    '{24'hE8FFFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hBEEF},
    '{24'hE90000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    '{24'h000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h7777},
    '{24'hF80000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h7777},
    '{24'h400000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic rd, input logic [15:0] wd);
    @(negedge clk);
    busAddr = a; busRead = rd; busWrData = wd; busSelect = 1; busNewAddr = 0; busIack = 0;
    #2;
  endtask

  task automatic cfgWrite(input logic [5:0] idx, input logic [1:0] m, input logic [5:0] b);
    @(negedge clk);
    busSelect = 0; cfgWe = 1; cfgIdx = idx; cfgMask = m; cfgBank = b;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; busSelect = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    #2;
    chk("R11 reset waitReq", {31'd0, waitReq}, 32'd0);
    chk("R12 idle vpa", {31'd0, vpa}, 32'd0);

    // Table-driven read decode (R1 R2 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 14; i++) begin
      access(VECS[i].addr, 1'b1, 16'h0);
      chk("R1 vpa", {31'd0, vpa}, {31'd0, VECS[i].vpa});
      chk("R2 selects", {30'd0, periphBSel, periphASel}, {30'd0, VECS[i].b, VECS[i].a});
      chk("R5 R6 windows", {30'd0, customSel, expSel}, {30'd0, VECS[i].cus, VECS[i].ex});
      chk("R8 memSel", {31'd0, memSel}, {31'd0, VECS[i].mem});
      chk("R4 R7 rdData", {16'd0, busRdData}, {16'd0, VECS[i].rd});
    end

    // R2 register index
    access(24'hBFE700, 1'b1, 16'h0);
    chk("R2 periphReg", {28'd0, periphReg}, 32'h7);

    // R9 boot map banks
    access(24'h000000, 1'b1, 16'h0);
    chk("R9 overlay bank", {26'd0, memBank}, 32'd63);
    access(24'h1C0000, 1'b0, 16'h0);
    chk("R9 ram region 7 writable", {30'd0, memSel, memWrEn}, 32'b11);
    chk("R9 ram bank", {26'd0, memBank}, 32'd7);
    access(24'hF80000, 1'b1, 16'h0);
    chk("R9 rom bank", {26'd0, memBank}, 32'd62);

    // R3 peripheral write lanes
    access(24'hBFC000, 1'b0, 16'hABCD);
    chk("R3 periphWrEn", {31'd0, periphWrEn}, 32'd1);
    chk("R3 lane data", {16'd0, periphBWrData, periphAWrData}, 32'h0000ABCD);
    access(24'hBFC000, 1'b1, 16'hABCD);
    chk("R3 no write strobe on read", {31'd0, periphWrEn}, 32'd0);

    // R7 unmapped write: no select
    access(24'h400000, 1'b0, 16'h5555);
    chk("R7 unmapped write selects", {28'd0, memSel, periphASel|periphBSel, customSel, expSel}, 32'd0);

    // R8 write to read-only region ignored
    access(24'h000000, 1'b0, 16'h1111);
    chk("R8 rom write blocked", {30'd0, memSel, memWrEn}, 32'd0);

    // R10 reconfigure region 0 as RAM bank 0
    cfgWrite(6'd0, 2'b11, 6'd0);
    access(24'h000000, 1'b0, 16'h1111);
    chk("R10 region0 writable", {30'd0, memSel, memWrEn}, 32'b11);
    chk("R10 region0 bank", {26'd0, memBank}, 32'd0);

    // R8 write-only region: read returns ones
    cfgWrite(6'd16, 2'b10, 6'd9);
    access(24'h400000, 1'b1, 16'h0);
    chk("R8 unreadable read data", {16'd0, busRdData}, 32'h0000FFFF);
    chk("R8 unreadable read memSel", {31'd0, memSel}, 32'd0);

    // R8 memory entry shadows peripheral window (region 47)
    cfgWrite(6'd47, 2'b11, 6'd5);
    access(24'hBFE001, 1'b1, 16'h0);
    chk("R8 shadow memSel", {31'd0, memSel}, 32'd1);
    chk("R8 shadow no periph", {30'd0, periphASel, periphBSel}, 32'd0);
    chk("R8 shadow data", {16'd0, busRdData}, 32'h00007777);
    chk("R1 shadow vpa", {31'd0, vpa}, 32'd1);

    // R9 reset restores boot map
    doReset();
    access(24'hBFE001, 1'b1, 16'h0);
    chk("R9 restored periph", {30'd0, periphASel, memSel}, 32'b10);
    access(24'h000000, 1'b1, 16'h0);
    chk("R9 restored overlay", {26'd0, memBank}, 32'd63);

    // R11 chip RAM wait
    @(negedge clk);
    busAddr = 24'h100000; busRead = 1; busSelect = 1; busNewAddr = 1; slotGrant = 0; #2;
    chk("R11 wait starts", {31'd0, waitReq}, 32'd1);
    @(negedge clk); busNewAddr = 0; #2;
    chk("R11 wait held", {31'd0, waitReq}, 32'd1);
    @(negedge clk); #2;
    chk("R11 wait held 2", {31'd0, waitReq}, 32'd1);
    @(negedge clk); slotGrant = 1; #2;
    chk("R11 wait released", {31'd0, waitReq}, 32'd0);
    @(negedge clk); slotGrant = 0; #2;
    chk("R11 wait stays low", {31'd0, waitReq}, 32'd0);
    @(negedge clk); busAddr = 24'h200000; busNewAddr = 1; #2;
    chk("R11 above chip RAM", {31'd0, waitReq}, 32'd0);
    @(negedge clk); busAddr = 24'h1FFFFE; slotGrant = 1; #2;
    chk("R11 immediate grant", {31'd0, waitReq}, 32'd0);
    @(negedge clk); busNewAddr = 0; slotGrant = 0; #2;
    chk("R11 no leftover", {31'd0, waitReq}, 32'd0);

    // R12 interrupt acknowledge
    @(negedge clk);
    busAddr = 24'h000000; busIack = 1; busNewAddr = 1; busSelect = 1; busRead = 1; #2;
    chk("R12 iack vpa", {31'd0, vpa}, 32'd1);
    chk("R12 iack no wait", {31'd0, waitReq}, 32'd0);
    chk("R12 iack no select", {31'd0, memSel}, 32'd0);
    chk("R12 iack data", {16'd0, busRdData}, 32'h0000FFFF);
    @(negedge clk); busAddr = 24'hBFC000; busNewAddr = 0; #2;
    chk("R12 iack periph quiet", {30'd0, periphASel, periphBSel}, 32'd0);
    @(negedge clk); busIack = 0; busSelect = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule